// File: doc/BRIEF.md
# Peripheral Interrupt Group Router

This block collects the level-sensitive interrupt lines of up to 64 peripherals and folds them onto nine general-purpose core interrupt groups. Each line passes a per-source enable bit. A programmable 4-bit code then selects the group it lands on, and code c drives group request bit c, which stands for core group c + 7. Any number of sources may share one group, and a group is requested while at least one enabled source routed to it is asserting.

A second path runs beside the interrupt path. A per-source wakeup-enable bit lets an asserting line raise a wakeup request without any clock edge, so the request still reaches the power logic while the core is idle or asleep. Software sees the raw line levels through two read-only status words. A simple single-cycle register bus gives access to the enable, status, wakeup and code registers. Group priority, the core pipeline and clock or power sequencing belong to other blocks.

Top module: `irq_group_router`

## Requirements
- R1: After reset the enable words and wakeup words read 0, the group request vector is 0, and the 4-bit code of source i is i mod 9.
- R2: A source reaches its group only while its enable bit is 1. Enable word 0 sits at address 0 and enable word 1 at address 1, and bit b of word w belongs to source 32*w+b. Clearing the bit blocks the source.
- R3: Status word 0 (address 2) and status word 1 (address 3) return the present level of sources 0-31 and 32-63 whatever the enable bits hold.
- R4: Writes to addresses 2 and 3 change nothing, and status reads still return the line levels.
- R5: wake_req is 1, in the same cycle and with no clock edge, exactly when some source is asserting while its wakeup bit is set. Wakeup word 0 is at address 4 and word 1 at address 5, and the enable bits have no effect on this output.
- R6: Code register k sits at address 8+k and holds the codes of sources 8k to 8k+7, with source 8k+j in bits 4j+3 down to 4j. A code c below 9 routes the source to grp_req bit c.
- R7: Codes 9 through 15 route the source to no group.
- R8: grp_req bit c is the OR of all enabled, asserting sources whose code is c. It is registered, so it follows its inputs one clock edge later.
- R9: A register write takes effect at the clock edge where bus_sel and bus_we are both 1. Reads are combinational from bus_addr. Addresses 6, 7 and 16 to 31 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| periph_irq | input | 64 | Peripheral interrupt levels |
| grp_req | output | 9 | Group requests, bit c = core group c+7 |
| wake_req | output | 1 | Wakeup request |

## Verification
A change on periph_irq shows on grp_req one clock edge later. A register write is committed on the edge that samples it, so its effect on grp_req appears one edge after that, two edges after the write is driven. wake_req and bus_rdata are combinational and are due in the same cycle. Each stimulus task stamps every expected value with the clock count at which it is due: the drive cycle plus one for line changes and reads, and plus two for group effects of a write. The monitor compares each value shortly after that edge and never between edges.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int MAX_SRC  = 64;
  localparam int CODE_W   = 4;
  localparam int GRP_BASE = 7;

  // Register word addresses; words of one kind are consecutive.
  localparam int A_ENABLE = 0;
  localparam int A_STATUS = 2;
  localparam int A_WAKE   = 4;
  localparam int A_CODE   = 8;

  // Reset code table: source i gets code i mod ngrp.
  function automatic logic [MAX_SRC*CODE_W-1:0] default_map(input int ngrp);
    logic [MAX_SRC*CODE_W-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_SRC; i++) m[i*CODE_W +: CODE_W] = CODE_W'(i % ngrp);
    return m;
  endfunction

  // True when a code selects request bit g (codes >= group count never match).
  function automatic logic routes_to(input logic [CODE_W-1:0] code, input int g);
    return (int'(code) == g);
  endfunction

  // Core group number served by request bit g.
  function automatic int group_number(input int g);
    return g + GRP_BASE;
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter logic [MAX_SRC*CODE_W-1:0] RESET_MAP = default_map(9)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]        irq_lvl,
  output logic [NUM_SRC-1:0]        mask_vec,
  output logic [NUM_SRC-1:0]        wake_vec,
  output logic [NUM_SRC*CODE_W-1:0] map_vec
);
  localparam int NUM_WORDS = NUM_SRC / DATA_W;
  localparam int PER_CODE  = DATA_W / CODE_W;
  localparam int NUM_CODE  = NUM_SRC / PER_CODE;

  logic wr_en;
  assign wr_en = bus_sel && bus_we;

  logic [NUM_SRC-1:0]        mask_q;
  logic [NUM_SRC-1:0]        wake_q;
  logic [NUM_SRC*CODE_W-1:0] map_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit_mask, hit_wake;
    assign hit_mask = wr_en && (bus_addr == ADDR_W'(A_ENABLE + w));
    assign hit_wake = wr_en && (bus_addr == ADDR_W'(A_WAKE + w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[w*DATA_W +: DATA_W] <= '0;
        wake_q[w*DATA_W +: DATA_W] <= '0;
      end else begin
        if (hit_mask) mask_q[w*DATA_W +: DATA_W] <= bus_wdata;
        if (hit_wake) wake_q[w*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  for (genvar k = 0; k < NUM_CODE; k++) begin : g_code
    logic hit_code;
    assign hit_code = wr_en && (bus_addr == ADDR_W'(A_CODE + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        map_q[k*DATA_W +: DATA_W] <= RESET_MAP[k*DATA_W +: DATA_W];
      else if (hit_code) map_q[k*DATA_W +: DATA_W] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (bus_addr == ADDR_W'(A_ENABLE + w)) bus_rdata = mask_q[w*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(A_STATUS + w)) bus_rdata = irq_lvl[w*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(A_WAKE + w))   bus_rdata = wake_q[w*DATA_W +: DATA_W];
    end
    for (int k = 0; k < NUM_CODE; k++)
      if (bus_addr == ADDR_W'(A_CODE + k)) bus_rdata = map_q[k*DATA_W +: DATA_W];
  end

  assign mask_vec = mask_q;
  assign wake_vec = wake_q;
  assign map_vec  = map_q;
endmodule

// File: rtl/irq_router_fanin.sv
module irq_router_fanin
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_GRP = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_lvl,
  input  logic [NUM_SRC-1:0]        mask_vec,
  input  logic [NUM_SRC*CODE_W-1:0] map_vec,
  output logic [NUM_GRP-1:0]        grp_req
);
  logic [NUM_SRC-1:0] live_src;
  logic [NUM_GRP-1:0] grp_next;

  assign live_src = irq_lvl & mask_vec;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
        if (live_src[i] && routes_to(map_vec[i*CODE_W +: CODE_W], g)) hit = 1'b1;
    end
    assign grp_next[g] = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_req <= '0;
    else        grp_req <= grp_next;
  end
endmodule

// File: rtl/irq_router_wake.sv
module irq_router_wake #(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] irq_lvl,
  input  logic [NUM_SRC-1:0] wake_vec,
  output logic               wake_req
);
  logic [NUM_SRC-1:0] wake_src;
  assign wake_src = irq_lvl & wake_vec;
  assign wake_req = |wake_src;
endmodule

// File: rtl/irq_group_router.sv
module irq_group_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_GRP = 9,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter logic [MAX_SRC*CODE_W-1:0] RESET_MAP = default_map(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] periph_irq,
  output logic [NUM_GRP-1:0] grp_req,
  output logic               wake_req
);
  logic [NUM_SRC-1:0]        mask_vec;
  logic [NUM_SRC-1:0]        wake_vec;
  logic [NUM_SRC*CODE_W-1:0] map_vec;

  irq_router_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_MAP(RESET_MAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl(periph_irq), .mask_vec(mask_vec), .wake_vec(wake_vec), .map_vec(map_vec)
  );

  irq_router_fanin #(.NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP)) u_fanin (
    .clk(clk), .rst_n(rst_n), .irq_lvl(periph_irq), .mask_vec(mask_vec),
    .map_vec(map_vec), .grp_req(grp_req)
  );

  irq_router_wake #(.NUM_SRC(NUM_SRC)) u_wake (
    .irq_lvl(periph_irq), .wake_vec(wake_vec), .wake_req(wake_req)
  );
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_GRP = 9,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_sel,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NUM_SRC-1:0]        irq_lvl,
  input logic [NUM_GRP-1:0]        grp_req,
  input logic                      wake_req,
  input logic [NUM_SRC-1:0]        mask_vec,
  input logic [NUM_SRC-1:0]        wake_vec,
  input logic [NUM_SRC*CODE_W-1:0] map_vec
);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl == '0) |=> (grp_req == '0));

  assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '0) |=> (grp_req == '0));

  assert_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_vec == '0) |-> !wake_req);

  assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_STATUS)) |-> (bus_rdata == irq_lvl[DATA_W-1:0]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> ($stable(mask_vec) && $stable(wake_vec) && $stable(map_vec)));
endmodule

bind irq_group_router irq_router_checker #(
  .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_lvl(periph_irq),
  .grp_req(grp_req), .wake_req(wake_req), .mask_vec(mask_vec),
  .wake_vec(wake_vec), .map_vec(map_vec)
);

// File: tb/irq_group_router_bench.sv
module irq_group_router_bench;
  localparam int NS = 64;
  localparam int NG = 9;

  localparam int K_GRP = 0;
  localparam int K_WAKE = 1;
  localparam int K_RD = 2;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] periph_irq = '0;
  logic [NG-1:0] grp_req;
  logic        wake_req;

  irq_group_router u_irq_group_router (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_irq(periph_irq), .grp_req(grp_req), .wake_req(wake_req)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  item_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model of the programmable state.
  logic [NS-1:0] m_irq = '0, m_en = '0, m_wk = '0;
  logic [3:0]    m_code [NS];

  function automatic logic [31:0] exp_grp();
    logic [31:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (m_irq[i] && m_en[i] && m_code[i] < 4'(NG)) r[m_code[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_wake();
    return {31'b0, (m_irq & m_wk) != '0};
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    logic [31:0] v = '0;
    case (a)
      0: v = m_en[31:0];
      1: v = m_en[63:32];
      2: v = m_irq[31:0];
      3: v = m_irq[63:32];
      4: v = m_wk[31:0];
      5: v = m_wk[63:32];
      default:
        if (a >= 8 && a < 16)
          for (int j = 0; j < 8; j++) v[j*4 +: 4] = m_code[(a-8)*8 + j];
    endcase
    return v;
  endfunction

  task automatic push(input int due, input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.due = due; it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive_irq(input logic [NS-1:0] v, input string tag);
    @(negedge clk);
    periph_irq = v;
    m_irq = v;
    push(cyc + 1, K_GRP, exp_grp(), tag);
    push(cyc + 1, K_WAKE, exp_wake(), tag);
  endtask

  task automatic reg_write(input int a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    case (a)
      0: m_en[31:0] = d;
      1: m_en[63:32] = d;
      4: m_wk[31:0] = d;
      5: m_wk[63:32] = d;
      default:
        if (a >= 8 && a < 16)
          for (int j = 0; j < 8; j++) m_code[(a-8)*8 + j] = d[j*4 +: 4];
    endcase
    push(cyc + 2, K_GRP, exp_grp(), tag);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic reg_read(input int a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(a);
    push(cyc + 1, K_RD, exp_read(a), tag);
  endtask

  // Monitor: compares each item just after the edge it is due at.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_GRP:   act = {23'b0, grp_req};
          K_WAKE:  act = {31'b0, wake_req};
          default: act = bus_rdata;
        endcase
        checks++;
        if (it.due != cyc || act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d cycle=%0d due=%0d actual=%h expected=%h",
                   it.tag, it.kind, cyc, it.due, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) m_code[i] = 4'(i % NG);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    push(cyc + 1, K_GRP, 32'h0, "R1");
    reg_read(0, "R1");
    reg_read(5, "R1");
    reg_read(8, "R1");
    reg_read(15, "R1");

    // R3 / R2: status follows lines while all enables are clear
    drive_irq(64'hA5A5_0F0F_1234_8001, "R2");
    reg_read(2, "R3");
    reg_read(3, "R3");

    // R5: wakeup path independent of enables
    reg_write(4, 32'h0000_0008, "R5");
    drive_irq(64'h0000_0000_0000_0008, "R5");
    drive_irq(64'h0000_0000_0000_0004, "R5");
    reg_write(5, 32'h8000_0000, "R5");
    drive_irq(64'h8000_0000_0000_0000, "R5");

    // R4: status is read-only
    reg_write(2, 32'hFFFF_FFFF, "R4");
    reg_read(2, "R4");
    reg_write(3, 32'h0000_0000, "R4");
    reg_read(3, "R4");

    // R9: unmapped addresses
    reg_write(6, 32'hDEAD_BEEF, "R9");
    reg_read(6, "R9");
    reg_write(20, 32'h1234_5678, "R9");
    reg_read(20, "R9");
    reg_read(0, "R9");

    // R2: enable word 0, then word 1
    reg_write(0, 32'hFFFF_FFFF, "R2");
    drive_irq(64'h0000_0001_0000_0010, "R2");
    reg_write(1, 32'h0000_0001, "R2");
    reg_read(1, "R2");
    reg_write(0, 32'hFFFF_FFEF, "R2");

    // R6: code register 5 covers sources 40..47
    reg_write(1, 32'hFFFF_FFFF, "R6");
    reg_write(13, 32'h2222_2222, "R6");
    drive_irq(64'h0000_1000_0000_0000, "R6");
    reg_write(13, 32'h0008_0000, "R6");
    reg_read(13, "R6");

    // R7: codes 9 and 15 drop, code 8 is the last valid
    reg_write(9, 32'h8F9F_9F9F, "R7");
    drive_irq(64'h0000_0000_0000_FF00, "R7");
    drive_irq(64'h0000_0000_0000_0100, "R7");
    drive_irq(64'h0000_0000_0000_8000, "R7");

    // R8: many sources into one group, then all lines
    reg_write(8, 32'h0000_0000, "R8");
    drive_irq(64'h0000_0000_0000_00FF, "R8");
    drive_irq(64'hFFFF_FFFF_FFFF_FFFF, "R8");
    drive_irq(64'h0, "R8");

    for (int n = 0; n < 24; n++) begin
      if (n % 6 == 0) reg_write(n % 2, $urandom, "R2");
      if (n % 8 == 3) reg_write(8 + (n % 8), $urandom, "R6");
      drive_irq({$urandom, $urandom}, "R8");
    end

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule